// File: doc/BRIEF.md
# Registered-Output Bit-Serial Adder

This block adds two unsigned operands of `WIDTH` bits by handling one bit pair per clock, starting at the least significant position. A synchronous load input captures both operands in parallel and clears the result. When load is released, the operand registers shift toward bit 0 and feed a four-state sequencer. The sequencer's two state bits hold the running carry and the current sum bit.

The sum bit comes straight from a state flip-flop, so no combinational path runs from the operand bits to the serial result. That bit arrives one cycle after its bit pair is consumed. To allow for this, the capture counter starts one higher than the operand width, and the first shift into the result register is a discarded placeholder. When the counter reaches zero, `done` rises. The result then holds until the next load. Any carry out of the top bit is dropped.

Top module: `serial_sum_moore`

## Requirements
- R1: While `loadRst` is high at a rising edge, the next outputs are `sumOut` = 0 and `done` = 0.
- R2: `WIDTH`+1 rising edges after the last edge with `loadRst` high, `sumOut` equals (`opA` + `opB`) mod 2^`WIDTH`, using the operands captured at that load.
- R3: `done` is 0 after `WIDTH` edges following the load and is 1 after `WIDTH`+1 edges.
- R4: Once `done` is 1, `sumOut` and `done` stay unchanged until the next load, whatever happens on `opA` and `opB`.
- R5: The carry state bit after each edge is the majority of the previous carry and the consumed bit pair.
- R6: The serial sum state bit after each edge is the XOR of the consumed bit pair and the previous carry. This bit drives the result register and depends on no input combinationally.
- R7: The carry out of bit `WIDTH`-1 is discarded. For example, all ones plus one gives 0.
- R8: A load that arrives in the middle of an operation restarts it, and the result is the sum of the newly loaded operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| loadRst | input | 1 | Synchronous operand load and state clear |
| opA | input | WIDTH | First operand, captured while loadRst is high |
| opB | input | WIDTH | Second operand, captured while loadRst is high |
| sumOut | output | WIDTH | Result register, valid once done is high |
| done | output | 1 | High when all result bits have been captured |

## Verification
A wrong carry or sum state first shows in the result bit for the position where the error occurred. A carry error also corrupts every higher bit, so operands with long carry chains, such as all ones plus one, expose it clearly. A counter that is off by one shows up one cycle early or late on `done`, and it also shifts the whole sum by one position. Each of these faults is visible at the ports once the result is read at `WIDTH`+1 cycles after load.

// File: rtl/sadd_pkg.sv
package sadd_pkg;
  // State bits: [1] = carry, [0] = sum bit being presented
  typedef enum logic [1:0] {
    NC_S0 = 2'b00,
    NC_S1 = 2'b01,
    CY_S0 = 2'b10,
    CY_S1 = 2'b11
  } seqState_t;

  typedef struct packed {
    logic load;
    logic sumShift;
  } ctrlStrobe_t;
endpackage

// File: rtl/sadd_shreg.sv
module sadd_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         load,
  input  logic         en,
  input  logic [W-1:0] parIn,
  input  logic         serIn,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (load) q <= parIn;
    else if (en) q <= {serIn, q[W-1:1]};
  end
endmodule

// File: rtl/sadd_seq.sv
module sadd_seq
  import sadd_pkg::*;
(
  input  logic clk,
  input  logic load,
  input  logic aBit,
  input  logic bBit,
  output logic sBit,
  output logic carryBit
);
  seqState_t state, stateNext;
  logic carryNext, sumNext;

  always_comb begin
    carryNext = (aBit & bBit) | (aBit & state[1]) | (bBit & state[1]);
    sumNext   = aBit ^ bBit ^ state[1];
    stateNext = seqState_t'({carryNext, sumNext});
  end

  always_ff @(posedge clk) begin
    if (load) state <= NC_S0;
    else state <= stateNext;
  end

  assign sBit     = state[0];
  assign carryBit = state[1];

  // R5: carry follows majority of prior carry and consumed pair
  assert_carry_majority_R5: assert property (@(posedge clk) disable iff (load)
    1'b1 |=> carryBit == (($past(aBit) & $past(bBit)) |
                          ($past(aBit) & $past(carryBit)) |
                          ($past(bBit) & $past(carryBit))));
  // R6: registered sum bit is parity of consumed pair and prior carry
  assert_sum_parity_R6: assert property (@(posedge clk) disable iff (load)
    1'b1 |=> sBit == ($past(aBit) ^ $past(bBit) ^ $past(carryBit)));
endmodule

// File: rtl/sadd_datapath.sv
module sadd_datapath
  import sadd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  ctrlStrobe_t      strobe,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sumReg
);
  logic [WIDTH-1:0] regA, regB;
  logic sBit, carryBit;

  sadd_shreg #(.W(WIDTH)) u_shA (
    .clk(clk), .load(strobe.load), .en(1'b1), .parIn(opA), .serIn(1'b0), .q(regA));
  sadd_shreg #(.W(WIDTH)) u_shB (
    .clk(clk), .load(strobe.load), .en(1'b1), .parIn(opB), .serIn(1'b0), .q(regB));

  sadd_seq u_seq (
    .clk(clk), .load(strobe.load), .aBit(regA[0]), .bBit(regB[0]),
    .sBit(sBit), .carryBit(carryBit));

  sadd_shreg #(.W(WIDTH)) u_shSum (
    .clk(clk), .load(strobe.load), .en(strobe.sumShift), .parIn('0),
    .serIn(sBit), .q(sumReg));

  // R1: load clears the result and the carry
  assert_load_clear_R1: assert property (@(posedge clk)
    strobe.load |=> (sumReg == '0) && !carryBit);
  // R4: result holds whenever no shift is requested
  assert_sum_hold_R4: assert property (@(posedge clk) disable iff (strobe.load)
    !strobe.sumShift |=> $stable(sumReg));
endmodule

// File: rtl/sadd_ctrl.sv
module sadd_ctrl
  import sadd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic        clk,
  input  logic        loadRst,
  output ctrlStrobe_t strobe,
  output logic        done
);
  localparam int CW = $clog2(WIDTH + 2);
  localparam logic [CW-1:0] PRESET = CW'(WIDTH + 1);

  logic [CW-1:0] count;
  logic run;

  assign run = (count != '0);

  always_ff @(posedge clk) begin
    if (loadRst) count <= PRESET;
    else if (run) count <= count - CW'(1);
  end

  always_comb begin
    strobe.load     = loadRst;
    strobe.sumShift = run & ~loadRst;
    done            = ~run;
  end

  // R3: counter steps down by one while running
  assert_count_step_R3: assert property (@(posedge clk) disable iff (loadRst)
    run |=> count == $past(count) - CW'(1));
  // R4: done stays high until the next load
  assert_done_sticky_R4: assert property (@(posedge clk) disable iff (loadRst)
    done |=> done);
  // R1: load presets the counter, done drops
  assert_load_preset_R1: assert property (@(posedge clk)
    loadRst |=> !done);
endmodule

// File: rtl/serial_sum_moore.sv
module serial_sum_moore
  import sadd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             loadRst,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sumOut,
  output logic             done
);
  ctrlStrobe_t strobe;

  sadd_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .loadRst(loadRst), .strobe(strobe), .done(done));

  sadd_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .strobe(strobe), .opA(opA), .opB(opB), .sumReg(sumOut));
endmodule

// File: tb/serial_sum_moore_bench.sv
module serial_sum_moore_bench;
  localparam int N = 8;
  localparam int NV = 8;
  localparam logic [2*N-1:0] VEC [NV] = '{
    16'h0000, 16'hFF01, 16'h5555, 16'hAAAA,
    16'h0F0F, 16'h8080, 16'h7F01, 16'hC3A5
  };

  logic clk = 0;
  logic loadRst = 1;
  logic [N-1:0] opA = '0, opB = '0;
  logic [N-1:0] sumOut;
  logic done;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  serial_sum_moore #(.WIDTH(N)) u_serial_sum_moore (
    .clk(clk), .loadRst(loadRst), .opA(opA), .opB(opB), .sumOut(sumOut), .done(done));

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic loadOps(input logic [N-1:0] a, input logic [N-1:0] b);
    @(negedge clk);
    loadRst = 1; opA = a; opB = b;
    @(negedge clk);
    loadRst = 0;
  endtask

  task automatic runOp(input logic [N-1:0] a, input logic [N-1:0] b, input string req);
    logic [N-1:0] exp;
    exp = N'((N+1)'(a) + (N+1)'(b));
    loadOps(a, b);
    repeat (N) @(negedge clk);
    check("R3 done low after N", {{(N-1){1'b0}}, done}, '0);
    @(negedge clk);
    check("R3 done high after N+1", {{(N-1){1'b0}}, done}, N'(1));
    check(req, sumOut, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    opA = 8'hFF; opB = 8'hFF;
    repeat (3) @(negedge clk);
    check("R1 sum cleared", sumOut, '0);
    check("R1 done low", {{(N-1){1'b0}}, done}, '0);

    // R2, R5, R6: table walk
    for (int i = 0; i < NV; i++)
      runOp(VEC[i][2*N-1:N], VEC[i][N-1:0], "R2 R5 R6 table sum");

    // R7: carry out discarded
    runOp(8'hFF, 8'h01, "R7 all ones plus one");
    runOp(8'hFF, 8'hFF, "R7 all ones plus all ones");
    runOp(8'h00, 8'h00, "R2 zero plus zero");

    // R4: hold after done despite operand changes
    runOp(8'h3C, 8'h41, "R2 pre-hold sum");
    opA = 8'hAA; opB = 8'h55;
    repeat (6) @(negedge clk);
    check("R4 sum held", sumOut, 8'h7D);
    check("R4 done held", {{(N-1){1'b0}}, done}, N'(1));

    // R1: load mid-hold clears outputs
    @(negedge clk);
    loadRst = 1;
    @(negedge clk);
    check("R1 reload clears sum", sumOut, '0);
    check("R1 reload clears done", {{(N-1){1'b0}}, done}, '0);
    loadRst = 0;

    // R8: restart mid operation
    loadOps(8'h12, 8'h34);
    repeat (3) @(negedge clk);
    runOp(8'hE7, 8'h2C, "R8 restart result");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule